// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

An 8-bit down-counting prescaler drives an 8-bit down-counting timer. Each stage keeps a reload latch. A counter holding zero does not underflow at once. It underflows on the next count pulse, and that pulse also reloads the counter from its latch. A loaded value n therefore divides its count rate by n+1. The timer counts one step for each prescaler underflow, so the pair divides the count source by (n+1)(m+1). Each timer underflow raises an interrupt request flag, which stays set until software clears it.

The count source depends on the operating mode. In timer mode one of two internal tick inputs feeds the prescaler. In event mode, edges on an external pin feed it instead. That pin is synchronised into the system clock and turned into single-cycle strobes. In pulse mode the timer underflow toggles an output pin, and a second pin can carry the inverse level. The output level is held in a two-state machine. State `LVL_HI` moves to `LVL_LO` on a timer underflow in pulse mode, and `LVL_LO` moves back to `LVL_HI` the same way. A write to the control register forces the state to `LVL_HI` or `LVL_LO` according to the polarity bit, and this forcing takes priority over the toggle.

Software reaches the block through a small register bus with four addresses. Address 0 is the prescaler, address 1 the timer, address 2 the control byte and address 3 the interrupt flag.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, both counters and both reload latches hold 0xFF. The control byte and the interrupt flag are 0, and both pulse pins are 0.
- R2: A write to address 0 (prescaler) or address 1 (timer) loads both the reload latch and the live counter with the written byte. A read of either address returns the live count, not the latch.
- R3: On each count pulse, a non-zero counter decrements by one. A counter holding zero instead reloads from its latch and produces an underflow, so a value n divides the pulse rate by n+1.
- R4: The timer receives one count pulse for each prescaler underflow, so the underflow period is (n+1)(m+1) source pulses.
- R5: The control byte has mode in bits [1:0] (00 timer, 01 pulse, 10 event, 11 behaves as timer). In timer mode and in mode 11, control bit 3 selects the prescaler source: 0 selects `tick_a`, 1 selects `tick_b`.
- R6: A timer underflow sets the interrupt flag, which `irq_req` shows and bit 0 of address 3 reads back. A write to address 3 with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it unchanged. An underflow in the same cycle as a clear leaves the flag set.
- R7: Control bit 2 is the polarity bit. A control write sets the output level to high when the polarity bit is 0 and to low when it is 1. In pulse mode each timer underflow inverts the level, and `pulse_out` shows the level.
- R8: In pulse mode, `pulse_out_n` carries the inverse of `pulse_out` when control bit 4 is 1, and is 0 when that bit is 0. Outside pulse mode both pins are 0.
- R9: In event mode the prescaler counts edges of `cnt_pin`: rising edges when the polarity bit is 0, falling edges when it is 1. The edge takes effect two clock cycles after it is sampled, and the internal ticks have no effect in this mode.
- R10: While control bit 5 (stop) is 1, neither counter changes on count pulses. Bus writes still load the counters.
- R11: A bus write to a counter in the same cycle as a count pulse for that counter takes priority. The written value is loaded and no underflow occurs for that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tick_a | input | 1 | Internal count source 0 (one-cycle strobes) |
| tick_b | input | 1 | Internal count source 1 (one-cycle strobes) |
| cnt_pin | input | 1 | External event input, asynchronous |
| pulse_out | output | 1 | Pulse-mode output level |
| pulse_out_n | output | 1 | Optional inverted pulse output |
| irq_req | output | 1 | Timer underflow interrupt request flag |

## Verification
The bench targets the zero-count reload. A design that underflows on reaching zero would divide by n instead of n+1, and the periods of the interrupt flag and the pulse output would drift from the model within one timer period. It also loads counters while count pulses arrive and changes the polarity bit between runs. A design that let the count win over the write, or that sampled the wrong edge of `cnt_pin`, would show a different live count on readback. Control writes issued while the output is in each of its two states check that the forced level does not depend on history. The stop bit and a set-versus-clear race on the interrupt flag are also exercised.

// File: rtl/prt_pkg.sv
package prt_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_RSVD  = 2'b11
    } prt_mode_e;

    typedef enum logic {
        LVL_HI = 1'b0,
        LVL_LO = 1'b1
    } prt_lvl_e;

    typedef struct packed {
        logic      stop;
        logic      inv_en;
        logic      src_sel;
        logic      pol;
        prt_mode_e mode;
    } prt_ctrl_t;

    localparam logic [1:0] ADDR_PRE  = 2'd0;
    localparam logic [1:0] ADDR_TMR  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_IRQ  = 2'd3;
endpackage

// File: rtl/prt_edge_sync.sv
module prt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel_fall,
    output logic strobe
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign strobe = sel_fall ? (sh[STAGES] & ~sh[STAGES-1])
                             : (sh[STAGES-1] & ~sh[STAGES]);

    // R9: an edge produces one strobe, never two back to back
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/prt_down_counter.sv
module prt_down_counter #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ce,
    output logic [W-1:0] cnt,
    output logic         uf
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= RST_VAL;
            latch_q <= RST_VAL;
        end else if (wr) begin
            cnt     <= wdata;
            latch_q <= wdata;
        end else if (ce) begin
            cnt <= (cnt == '0) ? latch_q : cnt - 1'b1;
        end
    end

    assign uf = ce & ~wr & (cnt == '0);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !wr && cnt == '0) |=> cnt == $past(latch_q));
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !wr) |=> $stable(cnt));
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt == $past(wdata));
endmodule

// File: rtl/prt_pulse_fsm.sv
module prt_pulse_fsm
    import prt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic init_low,
    input  logic tgl_en,
    input  logic uf,
    input  logic inv_en,
    output logic pulse_out,
    output logic pulse_out_n
);
    prt_lvl_e state, nxt;
    logic     lvl;

    always_comb begin
        nxt = state;
        if (init) begin
            nxt = init_low ? LVL_LO : LVL_HI;
        end else if (tgl_en && uf) begin
            unique case (state)
                LVL_HI: nxt = LVL_LO;
                LVL_LO: nxt = LVL_HI;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LVL_HI;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            LVL_HI: lvl = 1'b1;
            LVL_LO: lvl = 1'b0;
        endcase
        pulse_out   = tgl_en & lvl;
        pulse_out_n = tgl_en & inv_en & ~lvl;
    end

    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_en && uf && !init) |=> lvl != $past(lvl));
    p_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> lvl == !$past(init_low));
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
    import prt_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         tick_a,
    input  logic         tick_b,
    input  logic         cnt_pin,
    output logic         pulse_out,
    output logic         pulse_out_n,
    output logic         irq_req
);
    localparam int CTRL_W = $bits(prt_ctrl_t);

    logic [W-1:0] ctrl_q, pre_cnt, tmr_cnt;
    prt_ctrl_t    ctrl, ctrl_new;
    logic         wr_pre, wr_tmr, wr_ctrl, wr_irq;
    logic         evt_strobe, src_tick, pre_ce, pre_uf, tmr_uf;

    assign ctrl     = prt_ctrl_t'(ctrl_q[CTRL_W-1:0]);
    assign ctrl_new = prt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign wr_pre   = bus_wr && bus_addr == ADDR_PRE;
    assign wr_tmr   = bus_wr && bus_addr == ADDR_TMR;
    assign wr_ctrl  = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_irq   = bus_wr && bus_addr == ADDR_IRQ;

    prt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin),
        .sel_fall(ctrl.pol), .strobe(evt_strobe)
    );

    always_comb begin
        unique case (ctrl.mode)
            MODE_EVENT: src_tick = evt_strobe;
            default:    src_tick = ctrl.src_sel ? tick_b : tick_a;
        endcase
    end
    assign pre_ce = src_tick & ~ctrl.stop;

    prt_down_counter #(.W(W)) u_pre (
        .clk(clk), .rst_n(rst_n), .wr(wr_pre), .wdata(bus_wdata),
        .ce(pre_ce), .cnt(pre_cnt), .uf(pre_uf)
    );

    prt_down_counter #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .wr(wr_tmr), .wdata(bus_wdata),
        .ce(pre_uf), .cnt(tmr_cnt), .uf(tmr_uf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            irq_req <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (tmr_uf)                      irq_req <= 1'b1;
            else if (wr_irq && !bus_wdata[0]) irq_req <= 1'b0;
        end
    end

    prt_pulse_fsm u_pulse (
        .clk(clk), .rst_n(rst_n), .init(wr_ctrl), .init_low(ctrl_new.pol),
        .tgl_en(ctrl.mode == MODE_PULSE), .uf(tmr_uf), .inv_en(ctrl.inv_en),
        .pulse_out(pulse_out), .pulse_out_n(pulse_out_n)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_PRE:  bus_rdata = pre_cnt;
            ADDR_TMR:  bus_rdata = tmr_cnt;
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_IRQ:  bus_rdata = {{(W-1){1'b0}}, irq_req};
        endcase
    end

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf |=> irq_req);
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !(wr_irq && !bus_wdata[0])) |=> irq_req);
    p_timer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_uf && !wr_tmr) |=> $stable(tmr_cnt));
    p_outs_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_out && pulse_out_n));
endmodule

// File: tb/tb_prescaled_reload_timer.sv
module tb_prescaled_reload_timer;
    localparam int PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tick_a = 1'b0, tick_b = 1'b0, cnt_pin = 1'b0;
    logic       pulse_out, pulse_out_n, irq_req;

    prescaled_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_a(tick_a),
        .tick_b(tick_b), .cnt_pin(cnt_pin), .pulse_out(pulse_out),
        .pulse_out_n(pulse_out_n), .irq_req(irq_req)
    );

    always #(PERIOD/2) clk = ~clk;

    int    vectors = 0, miscompares = 0;
    string cur_req = "R1";
    bit    gate_a = 0, gate_b = 0;
    int    cyc = 0;

    // behavioural reference state
    int   m_pre, m_prel, m_tmr, m_tmrl;
    bit [7:0] m_ctrl;
    bit   m_irq, m_lvl;
    bit   h0, h1, h2;
    bit   evt, tick, ce, puf, tuf, wp, wt, wm, wi;
    bit [7:0] exp_rd;
    bit   exp_po, exp_pn;

    task automatic check(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 255; m_prel = 255; m_tmr = 255; m_tmrl = 255;
            m_ctrl = 0; m_irq = 0; m_lvl = 1; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            evt  = m_ctrl[2] ? (h2 && !h1) : (h1 && !h2);
            tick = (m_ctrl[1:0] == 2'b10) ? evt : (m_ctrl[3] ? tick_b : tick_a);
            ce   = tick && !m_ctrl[5];
            wp = bus_wr && bus_addr == 0; wt = bus_wr && bus_addr == 1;
            wm = bus_wr && bus_addr == 2; wi = bus_wr && bus_addr == 3;
            puf = ce && m_pre == 0 && !wp;
            if (wp) begin m_pre = bus_wdata; m_prel = bus_wdata; end
            else if (ce) m_pre = (m_pre == 0) ? m_prel : m_pre - 1;
            tuf = puf && m_tmr == 0 && !wt;
            if (wt) begin m_tmr = bus_wdata; m_tmrl = bus_wdata; end
            else if (puf) m_tmr = (m_tmr == 0) ? m_tmrl : m_tmr - 1;
            if (tuf) m_irq = 1;
            else if (wi && !bus_wdata[0]) m_irq = 0;
            if (wm) m_lvl = !bus_wdata[2];
            else if (m_ctrl[1:0] == 2'b01 && tuf) m_lvl = !m_lvl;
            if (wm) m_ctrl = bus_wdata;
            h2 = h1; h1 = h0; h0 = cnt_pin;
        end
        #1;
        case (bus_addr)
            2'd0: exp_rd = m_pre[7:0];
            2'd1: exp_rd = m_tmr[7:0];
            2'd2: exp_rd = m_ctrl;
            default: exp_rd = {7'd0, m_irq};
        endcase
        exp_po = (m_ctrl[1:0] == 2'b01) && m_lvl;
        exp_pn = (m_ctrl[1:0] == 2'b01) && m_ctrl[4] && !m_lvl;
        check("bus_rdata", bus_rdata, exp_rd);
        check("irq_req", irq_req, m_irq);
        check("pulse_out", pulse_out, exp_po);
        check("pulse_out_n", pulse_out_n, exp_pn);
    end

    always @(negedge clk) begin
        cyc++;
        tick_a = gate_a;
        tick_b = gate_b && (cyc % 3 == 0);
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic run(input int n, input bit drive_pin, input int pin_half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_addr = 2'(i % 4);
            if (drive_pin) cnt_pin = ((i / pin_half) % 2) == 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1 reset state, all four addresses
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run(8, 0, 1);
        cur_req = "R2";
        wr_reg(2, 8'h20);               // stop set, timer mode
        wr_reg(0, 8'h03);
        wr_reg(1, 8'h02);
        run(8, 0, 1);
        cur_req = "R3";                  // R4 also observed: 12-cycle timer period
        gate_a = 1;
        wr_reg(2, 8'h00);
        run(60, 0, 1);
        cur_req = "R5";
        gate_b = 1;
        wr_reg(2, 8'h08);
        run(40, 0, 1);
        cur_req = "R6";
        wr_reg(3, 8'h01);
        run(4, 0, 1);
        wr_reg(3, 8'h00);
        run(20, 0, 1);
        cur_req = "R7";
        wr_reg(2, 8'h01);               // pulse, start high, no inverse
        run(50, 0, 1);
        wr_reg(2, 8'h05);               // pulse, start low
        run(30, 0, 1);
        cur_req = "R8";
        wr_reg(2, 8'h11);
        run(40, 0, 1);
        wr_reg(2, 8'h15);
        run(30, 0, 1);
        cur_req = "R9";
        wr_reg(0, 8'h01);
        wr_reg(1, 8'h01);
        wr_reg(2, 8'h02);               // event, rising
        run(60, 1, 4);
        wr_reg(2, 8'h06);               // event, falling
        run(60, 1, 3);
        cur_req = "R10";
        wr_reg(2, 8'h20);
        run(20, 0, 1);
        wr_reg(0, 8'h05);
        run(8, 0, 1);
        cur_req = "R11";
        wr_reg(2, 8'h00);
        for (int k = 0; k < 6; k++) begin
            wr_reg(0, 8'h00);
            wr_reg(1, 8'h00);
            run(3, 0, 1);
        end
        cur_req = "R5";                 // reserved mode acts as timer
        wr_reg(2, 8'h03);
        run(30, 0, 1);
        cur_req = "R6";                 // underflow racing a clear
        wr_reg(0, 8'h00);
        wr_reg(1, 8'h00);
        for (int k = 0; k < 8; k++) wr_reg(3, 8'h00);
        run(6, 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule